// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address. It reads a four-level tree of translation tables in memory, one 8-byte entry per level. A request carries the virtual address, an access kind (data read, data write or instruction fetch) and a privilege flag. The walker follows the tree from a root frame given on an input. It then reports one of two results: the physical address with the effective rights, or a fault code.

Memory is reached through two ports. Entries are fetched on a read port, where the request uses valid/ready and the data returns with a separate valid strobe. After a successful translation, the updated leaf entry goes out on a write port (valid/ready), which marks the page as used and, for writes, as modified. Only one walk runs at a time. `busy` tells the requester when a new request would be accepted, and `done` marks the single cycle in which the result is presented.

Top module: `ptw_walker`

## Requirements
- R1: For level n (n = 0..3) the table index is virtual address bits [47-9n : 39-9n]. The entry address is the table frame times 4096 plus the index times 8. Level 0 uses `root_frame`, and each deeper level uses bits 51:12 of the entry read just before.
- R2: A walk reads exactly the levels 0, 1, 2, 3 in that order. It has at most one read outstanding. It holds `mem_rd_valid` and `mem_rd_addr` steady until `mem_rd_ready` is seen, and issues no new read until the data strobe has come back.
- R3: An entry whose bit 0 (present) is 0 ends the walk at once. No further read and no write follow, and `done_fault` = 1 with `done_paddr` = 0 and all reported rights 0.
- R4: The effective rights combine all four entries. The walk is writable only if bit 1 is set at every level, user-accessible only if bit 2 is set at every level, and non-executable if bit 63 is set at any level.
- R5: A write (`req_acc` = 1) to a page that is not effectively writable faults with code 2, whatever the privilege.
- R6: A user access (`req_user` = 1) to a page that is not effectively user-accessible faults with code 3. When several checks fail, code 3 wins over code 2, and code 2 wins over code 4. A fault reports `done_paddr` = 0 and all rights 0.
- R7: A fetch (`req_acc` = 2) from an effectively non-executable page faults with code 4. A `req_acc` of 0 or 3 is a read and never raises code 2 or 4.
- R8: On success `done_fault` = 0 and `done_paddr` = {leaf bits 51:12, virtual bits 11:0}. `done_writable`, `done_user` and `done_exec` give the effective writable, user and not-non-executable rights.
- R9: On success the leaf is written back to its own address with bit 5 set, and with bit 6 also set for a write. The write happens only if this changes the entry. It is held until `mem_wr_ready`, and `done` follows in the next cycle. A faulting walk writes nothing.
- R10: `busy` rises the cycle after a request is accepted and falls the cycle after the `done` pulse, which lasts one cycle. Requests seen while `busy` is high are ignored.
- R11: In reset and right after it, `busy`, `done`, `mem_rd_valid` and `mem_wr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_frame | input | 40 | Frame number of the level-0 table |
| req_valid | input | 1 | Translation request, taken when `busy` is low |
| req_vaddr | input | 48 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| req_user | input | 1 | 1 for a user-mode access |
| busy | output | 1 | A walk is in progress |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 52 | Byte address of the entry |
| mem_rd_data_valid | input | 1 | Read data strobe |
| mem_rd_data | input | 64 | Entry returned by memory |
| mem_wr_valid | output | 1 | Leaf write-back request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | 52 | Byte address of the leaf entry |
| mem_wr_data | output | 64 | Updated leaf entry |
| done | output | 1 | One-cycle result strobe |
| done_fault | output | 3 | 0 none, 1 not present, 2 read-only, 3 supervisor page, 4 no-execute |
| done_paddr | output | 52 | Translated physical address, 0 on fault |
| done_writable | output | 1 | Effective write right |
| done_user | output | 1 | Effective user right |
| done_exec | output | 1 | Effective execute right |

## Verification
A request is accepted at a clock edge and `busy` is high from the next cycle. Each read's address appears in the cycle after the previous data strobe, or after acceptance for the first read. `done` rises in the cycle after the last data strobe, or after the write-back handshake when one is needed. The memory model answers with random ready and random latency, so the result time varies from walk to walk. For that reason the bench does not count cycles. It waits at falling edges for `done` and compares every result field, the logged read addresses, the write-back count and contents at that sample. One cycle later it checks that `done` has fallen and `busy` is low.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W     = 48;
    localparam int PA_W     = 52;
    localparam int PG_SH    = 12;
    localparam int IDX_W    = 9;
    localparam int LEVELS   = 4;
    localparam int PTE_W    = 64;
    localparam int FRAME_W  = PA_W - PG_SH;
    localparam int VPN_W    = VA_W - PG_SH;
    localparam int LVL_W    = $clog2(LEVELS);
    localparam int ENTRY_SH = $clog2(PTE_W / 8);
    localparam int FAULT_W  = 3;

    // entry bit positions
    localparam int PTE_P  = 0;
    localparam int PTE_RW = 1;
    localparam int PTE_US = 2;
    localparam int PTE_A  = 5;
    localparam int PTE_D  = 6;
    localparam int PTE_NX = 63;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } acc_e;

    typedef enum logic [FAULT_W-1:0] {
        FLT_NONE   = 3'd0,
        FLT_ABSENT = 3'd1,
        FLT_RO     = 3'd2,
        FLT_PRIV   = 3'd3,
        FLT_NOEXEC = 3'd4
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WB,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic wr;
        logic usr;
        logic nx;
    } rights_t;

    localparam rights_t RIGHTS_ALL  = '{wr: 1'b1, usr: 1'b1, nx: 1'b0};
    localparam rights_t RIGHTS_NONE = '{wr: 1'b0, usr: 1'b0, nx: 1'b1};

    function automatic logic [FRAME_W-1:0] pte_frame(input logic [PTE_W-1:0] e);
        return e[PA_W-1:PG_SH];
    endfunction

    function automatic rights_t pte_rights(input logic [PTE_W-1:0] e);
        rights_t r;
        r.wr  = e[PTE_RW];
        r.usr = e[PTE_US];
        r.nx  = e[PTE_NX];
        return r;
    endfunction

    function automatic rights_t rights_merge(input rights_t a, input rights_t b);
        rights_t r;
        r.wr  = a.wr & b.wr;
        r.usr = a.usr & b.usr;
        r.nx  = a.nx | b.nx;
        return r;
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [VPN_W-1:0]   vpn,
    input  logic [LVL_W-1:0]   level,
    input  logic [FRAME_W-1:0] table_frame,
    output logic [PA_W-1:0]    entry_addr
);

    logic [IDX_W-1:0] idx [LEVELS];

    // level 0 takes the highest index field, the last level the lowest
    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx[g] = vpn[VPN_W-1-g*IDX_W -: IDX_W];
    end

    logic [IDX_W-1:0]          sel_idx;
    logic [IDX_W+ENTRY_SH-1:0] byte_off;

    assign sel_idx    = idx[level];
    assign byte_off   = {sel_idx, {ENTRY_SH{1'b0}}};
    assign entry_addr = {table_frame, {PG_SH{1'b0}}} + PA_W'(byte_off);

endmodule

// File: rtl/ptw_rights.sv
module ptw_rights
    import ptw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    step,
    input  rights_t entry_r,
    input  acc_e    acc,
    input  logic    user,
    output rights_t eff,
    output fault_e  fault
);

    rights_t acc_r;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            acc_r <= RIGHTS_ALL;
        end else if (step) begin
            acc_r <= rights_merge(acc_r, entry_r);
        end
    end

    // rights including the entry currently on the read data bus
    assign eff = rights_merge(acc_r, entry_r);

    always_comb begin
        fault = FLT_NONE;
        if (user && !eff.usr) begin
            fault = FLT_PRIV;
        end else if (acc == ACC_WRITE && !eff.wr) begin
            fault = FLT_RO;
        end else if (acc == ACC_FETCH && eff.nx) begin
            fault = FLT_NOEXEC;
        end
    end

endmodule

// File: rtl/ptw_leaf_upd.sv
module ptw_leaf_upd
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] leaf_in,
    input  logic             is_write,
    output logic [PTE_W-1:0] leaf_out,
    output logic             changed
);

    logic [PTE_W-1:0] set_mask;

    always_comb begin
        set_mask        = '0;
        set_mask[PTE_A] = 1'b1;
        set_mask[PTE_D] = is_write;
    end

    assign leaf_out = leaf_in | set_mask;
    assign changed  = (leaf_out != leaf_in);

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [FRAME_W-1:0] root_frame,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [1:0]         req_acc,
    input  logic               req_user,
    output logic               busy,
    output logic               mem_rd_valid,
    input  logic               mem_rd_ready,
    output logic [PA_W-1:0]    mem_rd_addr,
    input  logic               mem_rd_data_valid,
    input  logic [PTE_W-1:0]   mem_rd_data,
    output logic               mem_wr_valid,
    input  logic               mem_wr_ready,
    output logic [PA_W-1:0]    mem_wr_addr,
    output logic [PTE_W-1:0]   mem_wr_data,
    output logic               done,
    output logic [FAULT_W-1:0] done_fault,
    output logic [PA_W-1:0]    done_paddr,
    output logic               done_writable,
    output logic               done_user,
    output logic               done_exec
);

    state_e             state;
    logic [LVL_W-1:0]   level;
    logic [FRAME_W-1:0] base_q;
    logic [VA_W-1:0]    vaddr_q;
    acc_e               acc_q;
    logic               user_q;
    logic [PA_W-1:0]    wb_addr_q;
    logic [PTE_W-1:0]   wb_data_q;
    fault_e             fault_q;
    logic [PA_W-1:0]    paddr_q;
    rights_t            rights_q;

    logic               accept;
    logic               rsp;
    logic               present;
    logic               at_leaf;
    logic               step;
    logic [PA_W-1:0]    walk_addr;
    rights_t            eff;
    fault_e             leaf_fault;
    logic [PTE_W-1:0]   leaf_new;
    logic               leaf_changed;

    assign accept  = (state == ST_IDLE) && req_valid;
    assign rsp     = (state == ST_RD_WAIT) && mem_rd_data_valid;
    assign present = mem_rd_data[PTE_P];
    assign at_leaf = (level == LVL_W'(LEVELS - 1));
    assign step    = rsp && present && !at_leaf;

    ptw_addr_gen u_addr (
        .vpn         (vaddr_q[VA_W-1:PG_SH]),
        .level       (level),
        .table_frame (base_q),
        .entry_addr  (walk_addr)
    );

    ptw_rights u_rights (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .step    (step),
        .entry_r (pte_rights(mem_rd_data)),
        .acc     (acc_q),
        .user    (user_q),
        .eff     (eff),
        .fault   (leaf_fault)
    );

    ptw_leaf_upd u_leaf (
        .leaf_in  (mem_rd_data),
        .is_write (acc_q == ACC_WRITE),
        .leaf_out (leaf_new),
        .changed  (leaf_changed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            level     <= '0;
            base_q    <= '0;
            vaddr_q   <= '0;
            acc_q     <= ACC_READ;
            user_q    <= 1'b0;
            wb_addr_q <= '0;
            wb_data_q <= '0;
            fault_q   <= FLT_NONE;
            paddr_q   <= '0;
            rights_q  <= RIGHTS_NONE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state    <= ST_RD_REQ;
                        level    <= '0;
                        base_q   <= root_frame;
                        vaddr_q  <= req_vaddr;
                        acc_q    <= acc_e'(req_acc);
                        user_q   <= req_user;
                        fault_q  <= FLT_NONE;
                        paddr_q  <= '0;
                        rights_q <= RIGHTS_NONE;
                    end
                end
                ST_RD_REQ: begin
                    if (mem_rd_ready) begin
                        state <= ST_RD_WAIT;
                    end
                end
                ST_RD_WAIT: begin
                    if (mem_rd_data_valid) begin
                        if (!present) begin
                            fault_q <= FLT_ABSENT;
                            state   <= ST_DONE;
                        end else if (!at_leaf) begin
                            level  <= level + LVL_W'(1);
                            base_q <= pte_frame(mem_rd_data);
                            state  <= ST_RD_REQ;
                        end else if (leaf_fault != FLT_NONE) begin
                            fault_q <= leaf_fault;
                            state   <= ST_DONE;
                        end else begin
                            paddr_q  <= {pte_frame(mem_rd_data), vaddr_q[PG_SH-1:0]};
                            rights_q <= eff;
                            if (leaf_changed) begin
                                wb_addr_q <= walk_addr;
                                wb_data_q <= leaf_new;
                                state     <= ST_WB;
                            end else begin
                                state <= ST_DONE;
                            end
                        end
                    end
                end
                ST_WB: begin
                    if (mem_wr_ready) begin
                        state <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign busy          = (state != ST_IDLE);
    assign mem_rd_valid  = (state == ST_RD_REQ);
    assign mem_rd_addr   = walk_addr;
    assign mem_wr_valid  = (state == ST_WB);
    assign mem_wr_addr   = wb_addr_q;
    assign mem_wr_data   = wb_data_q;
    assign done          = (state == ST_DONE);
    assign done_fault    = fault_q;
    assign done_paddr    = paddr_q;
    assign done_writable = rights_q.wr;
    assign done_user     = rights_q.usr;
    assign done_exec     = !rights_q.nx;

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker
    import ptw_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               busy,
    input logic               mem_rd_valid,
    input logic               mem_rd_ready,
    input logic [PA_W-1:0]    mem_rd_addr,
    input logic               mem_wr_valid,
    input logic               mem_wr_ready,
    input logic [PA_W-1:0]    mem_wr_addr,
    input logic [PTE_W-1:0]   mem_wr_data,
    input logic               done,
    input logic [FAULT_W-1:0] done_fault,
    input logic [PA_W-1:0]    done_paddr
);

    AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (rst) mem_rd_valid |-> (mem_rd_addr[ENTRY_SH-1:0] == '0)); // R1
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst) (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R2
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst) (mem_rd_valid && mem_rd_ready) |=> !mem_rd_valid); // R2
    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (rst) (done && done_fault != '0) |-> (done_paddr == '0)); // R3
    AST_FAULT_RANGE: assert property (@(posedge clk) disable iff (rst) done |-> (done_fault <= 3'd4)); // R6
    AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (rst) mem_wr_valid |-> mem_wr_data[PTE_A]); // R9
    AST_WB_HOLD: assert property (@(posedge clk) disable iff (rst) (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data))); // R9
    AST_DONE_AFTER_WB: assert property (@(posedge clk) disable iff (rst) (mem_wr_valid && mem_wr_ready) |=> done); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R10
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst) (req_valid && !busy) |=> busy); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !busy |-> (!mem_rd_valid && !mem_wr_valid && !done)); // R10

endmodule

bind ptw_walker ptw_checker u_ptw_checker (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .busy         (busy),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_ready (mem_wr_ready),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .done         (done),
    .done_fault   (done_fault),
    .done_paddr   (done_paddr)
);

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
    import ptw_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam logic [39:0] ROOT = 40'h00_0000_0800;
    localparam int TBL_BASE = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [47:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 1'b0;
    logic        busy;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [51:0] mem_rd_addr;
    logic        mem_rd_data_valid = 1'b0;
    logic [63:0] mem_rd_data = '0;
    logic        mem_wr_valid;
    logic        mem_wr_ready = 1'b0;
    logic [51:0] mem_wr_addr;
    logic [63:0] mem_wr_data;
    logic        done;
    logic [2:0]  done_fault;
    logic [51:0] done_paddr;
    logic        done_writable, done_user, done_exec;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_walker dut (
        .clk(clk), .rst(rst), .root_frame(ROOT),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_acc(req_acc), .req_user(req_user),
        .busy(busy),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data_valid(mem_rd_data_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .done(done), .done_fault(done_fault), .done_paddr(done_paddr),
        .done_writable(done_writable), .done_user(done_user), .done_exec(done_exec)
    );

    // ---------------- memory model ----------------
    logic [63:0] mem [logic [51:0]];
    int          rd_cnt, wr_cnt;
    logic [51:0] rd_log [8];
    logic [51:0] wr_addr_seen;
    logic [63:0] wr_data_seen;
    logic        pend = 1'b0;
    logic [51:0] pend_addr;
    int          pend_dly;

    function automatic logic [63:0] rdmem(input logic [51:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'h0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            pend              <= 1'b0;
            mem_rd_data_valid <= 1'b0;
            mem_rd_ready      <= 1'b0;
            mem_wr_ready      <= 1'b0;
        end else begin
            mem_rd_data_valid <= 1'b0;
            if (mem_rd_valid && mem_rd_ready) begin
                pend      <= 1'b1;
                pend_addr <= mem_rd_addr;
                pend_dly  <= int'($urandom % 3);
                if (rd_cnt < 8) rd_log[rd_cnt] = mem_rd_addr;
                rd_cnt = rd_cnt + 1;
            end else if (pend) begin
                if (pend_dly == 0) begin
                    mem_rd_data_valid <= 1'b1;
                    mem_rd_data       <= rdmem(pend_addr);
                    pend              <= 1'b0;
                end else begin
                    pend_dly <= pend_dly - 1;
                end
            end
            if (mem_wr_valid && mem_wr_ready) begin
                mem[mem_wr_addr] = mem_wr_data;
                wr_addr_seen = mem_wr_addr;
                wr_data_seen = mem_wr_data;
                wr_cnt = wr_cnt + 1;
            end
            mem_rd_ready <= ($urandom % 4) != 0;
            mem_wr_ready <= ($urandom % 3) != 0;
        end
    end

    // ---------------- checking ----------------
    int checks = 0;
    int errors = 0;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // expected results
    logic [2:0]  exp_f;
    logic [51:0] exp_pa;
    logic        exp_w, exp_u, exp_x;
    int          exp_nrd;
    logic [51:0] exp_addr [4];
    logic        exp_wb;
    logic [63:0] exp_wbd;

    task automatic model(input logic [47:0] va, input logic [1:0] acc, input logic usr);
        logic [39:0] fr;
        logic aw, au, anx;
        logic [63:0] e;
        logic [63:0] nd;
        fr = ROOT; aw = 1; au = 1; anx = 0; e = '0;
        exp_f = 0; exp_pa = 0; exp_w = 0; exp_u = 0; exp_x = 0; exp_wb = 0; exp_wbd = 0;
        for (int l = 0; l < 4; l++) begin
            logic [8:0] idx;
            idx = va[47-9*l -: 9];
            exp_addr[l] = {fr, 12'h000} + {40'h0, idx, 3'b000};
            exp_nrd = l + 1;
            e = rdmem(exp_addr[l]);
            if (!e[0]) begin
                exp_f = 3'd1;
                return;
            end
            aw &= e[1]; au &= e[2]; anx |= e[63];
            fr = e[51:12];
        end
        if (usr && !au)               exp_f = 3'd3;
        else if (acc == 2'd1 && !aw)  exp_f = 3'd2;
        else if (acc == 2'd2 && anx)  exp_f = 3'd4;
        if (exp_f != 0) return;
        exp_pa = {fr, va[11:0]};
        exp_w = aw; exp_u = au; exp_x = !anx;
        nd = e | 64'h20 | ((acc == 2'd1) ? 64'h40 : 64'h0);
        exp_wb = (nd != e);
        exp_wbd = nd;
    endtask

    function automatic logic [63:0] fl(input logic p, input logic rw, input logic us,
                                       input logic nx, input logic a, input logic d);
        return {nx, 56'h0, d, a, 2'b00, us, rw, p};
    endfunction

    // writes one path of four entries; tables are private to each tag
    task automatic build(input logic [47:0] va, input logic [3:0][63:0] flags,
                         input logic [39:0] leaf_frame, input int tag);
        logic [39:0] fr, nxt;
        fr = ROOT;
        for (int l = 0; l < 4; l++) begin
            logic [51:0] a;
            a = {fr, 12'h000} + {40'h0, va[47-9*l -: 9], 3'b000};
            nxt = (l == 3) ? leaf_frame : 40'(TBL_BASE + tag*4 + l);
            mem[a] = flags[l] | {12'h0, nxt, 12'h000};
            fr = nxt;
        end
    endtask

    task automatic run(input logic [47:0] va, input logic [1:0] acc, input logic usr, input string note);
        int t;
        string rq;
        model(va, acc, usr);
        rq = (exp_f == 1) ? "R3" : (exp_f == 2) ? "R5" : (exp_f == 3) ? "R6" : (exp_f == 4) ? "R7" : "R8";
        rd_cnt = 0; wr_cnt = 0;
        @(negedge clk);
        req_valid = 1; req_vaddr = va; req_acc = acc; req_user = usr;
        @(negedge clk);
        req_valid = 0;
        t = 0;
        while (!done && t < 400) begin
            @(negedge clk);
            t++;
        end
        chk("R10", {note, " done seen"}, 64'(done), 64'd1);
        chk(rq, {note, " fault"}, 64'(done_fault), 64'(exp_f));
        chk(rq, {note, " paddr"}, 64'(done_paddr), 64'(exp_pa));
        chk("R4", {note, " rights"}, {61'h0, done_writable, done_user, done_exec}, {61'h0, exp_w, exp_u, exp_x});
        chk("R2", {note, " read count"}, 64'(rd_cnt), 64'(exp_nrd));
        for (int l = 0; l < 4; l++)
            if (l < exp_nrd && l < rd_cnt) chk("R1", {note, " read address"}, 64'(rd_log[l]), 64'(exp_addr[l]));
        chk("R9", {note, " write count"}, 64'(wr_cnt), 64'(exp_wb));
        if (exp_wb && wr_cnt == 1) begin
            chk("R9", {note, " write address"}, 64'(wr_addr_seen), 64'(exp_addr[3]));
            chk("R9", {note, " write data"}, wr_data_seen, exp_wbd);
        end
        @(negedge clk);
        chk("R10", {note, " done pulse ends"}, 64'(done), 64'd0);
        chk("R10", {note, " busy drops"}, 64'(busy), 64'd0);
    endtask

    logic [63:0] OKF;
    initial begin
        logic [3:0][63:0] fg;
        logic [47:0] va;
        void'($urandom(32'd20240611));
        rd_cnt = 0; wr_cnt = 0;
        OKF = fl(1, 1, 1, 0, 0, 0);
        repeat (4) @(negedge clk);
        chk("R11", "reset outputs", {60'h0, busy, done, mem_rd_valid, mem_wr_valid}, 64'h0);
        rst = 0;
        @(negedge clk);
        chk("R11", "after reset outputs", {60'h0, busy, done, mem_rd_valid, mem_wr_valid}, 64'h0);

        // R8/R9: plain read, leaf gets accessed bit
        va = 48'h1234_5678_9ABC;
        fg = {OKF, OKF, OKF, OKF};
        build(va, fg, 40'hAB_CDEF_0123, 1);
        run(va, 2'd0, 1'b1, "R8 user read");
        chk("R9", "leaf in memory after read", rdmem(exp_addr[3]), exp_wbd);
        // R9: write on the same page sets dirty
        run(va, 2'd1, 1'b1, "R9 write sets dirty");
        // R9: already accessed and dirty: no write-back
        run(va, 2'd1, 1'b0, "R9 no change no write");
        run(va, 2'd0, 1'b0, "R9 read on marked leaf");

        // R3: absent at each level
        for (int l = 0; l < 4; l++) begin
            va = {9'(l + 3), 9'(l * 7 + 1), 9'(l + 100), 9'(l * 3 + 5), 12'h345};
            fg = {OKF, OKF, OKF, OKF};
            fg[l][0] = 1'b0;
            build(va, fg, 40'h55_0000_0000 + 40'(l), 10 + l);
            run(va, 2'd0, 1'b0, "R3 absent level");
        end

        // R4/R5: read-only at an upper level blocks a write, even in supervisor mode
        va = 48'h7F00_1122_3000;
        fg = {OKF, OKF, fl(1, 0, 1, 0, 0, 0), OKF};
        build(va, fg, 40'h00_1111_2222, 20);
        run(va, 2'd1, 1'b0, "R5 supervisor write read-only upper");
        run(va, 2'd1, 1'b1, "R5 user write read-only upper");
        run(va, 2'd0, 1'b1, "R4 read on read-only page");
        // R7: access code 3 behaves as a read
        run(va, 2'd3, 1'b1, "R7 code 3 read");

        // R6: supervisor-only at level 2, priority over write fault
        va = 48'h0000_8040_2FFF;
        fg = {OKF, fl(1, 0, 0, 1, 0, 0), OKF, OKF};
        build(va, fg, 40'h00_2222_3333, 21);
        run(va, 2'd0, 1'b1, "R6 user read supervisor page");
        run(va, 2'd1, 1'b1, "R6 user write priority over read-only");
        run(va, 2'd2, 1'b1, "R6 user fetch priority over no-exec");
        run(va, 2'd1, 1'b0, "R6 supervisor write read-only gives code 2");
        run(va, 2'd2, 1'b0, "R7 supervisor fetch no-exec");

        // R7: no-exec on the root level; writes and reads unaffected
        va = 48'hFFFF_FFFF_FFFF;
        fg = {OKF, OKF, OKF, fl(1, 1, 1, 1, 0, 0)};
        build(va, fg, 40'hFF_FFFF_FFFF, 22);
        run(va, 2'd2, 1'b1, "R7 fetch no-exec root");
        run(va, 2'd1, 1'b1, "R7 write on no-exec page");
        run(va, 2'd0, 1'b1, "R8 max indices and offset");

        // R10: a request while busy is ignored
        begin
            logic [47:0] vb;
            va = 48'h0101_0202_0303;
            vb = 48'h4040_5050_6060;
            fg = {OKF, OKF, OKF, OKF};
            build(va, fg, 40'h12_3456_789A, 30);
            build(vb, fg, 40'h9A_8765_4321, 31);
            model(va, 2'd0, 1'b0);
            rd_cnt = 0; wr_cnt = 0;
            @(negedge clk);
            req_valid = 1; req_vaddr = va; req_acc = 2'd0; req_user = 0;
            @(negedge clk);
            req_vaddr = vb; req_acc = 2'd1;
            @(negedge clk);
            req_valid = 0;
            for (int t = 0; t < 400 && !done; t++) @(negedge clk);
            chk("R10", "busy request ignored paddr", 64'(done_paddr), 64'(exp_pa));
            repeat (6) @(negedge clk);
            chk("R10", "busy request ignored reads", 64'(rd_cnt), 64'd4);
            chk("R10", "busy request ignored idle", 64'(busy), 64'd0);
        end

        // random walks
        for (int i = 0; i < 60; i++) begin
            for (int l = 0; l < 4; l++) begin
                fg[l] = fl(($urandom % 16) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0,
                           ($urandom % 6) == 0, $urandom % 2, $urandom % 2);
            end
            va = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
            build(va, fg, {$urandom, $urandom} & 40'hFF_FFFF_FFFF, 100 + i);
            run(va, 2'($urandom % 4), 1'($urandom % 2), "random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule